// File: doc/BRIEF.md
# Multi-Channel Interrupt Router

This block takes a bank of level-sensitive interrupt source lines and spreads them over several output channels, each of which drives one interrupt input of the processor's interrupt controller. Every channel has its own enable mask. A channel raises its output while any source it has enabled is high. It also offers a vector word that names the lowest-numbered enabled source that is currently active, so a handler can dispatch without scanning.

The sources are not latched. A channel's output and its vector follow the present level of the enabled lines. A source that drops before software reads the vector vanishes from it, and the vector then reads zero. Handlers must treat a decoded index below the table offset as a spurious entry. A per-channel reset bit returns one channel to its power-up state. Software reaches all registers through a simple synchronous valid/write/address/data port, with read data registered one cycle after the request.

Top module: `irq_router`

## Requirements
- R1: After global reset every enable mask reads 0, every channel output is low and every vector reads 0, even with all sources high.
- R2: The enable mask of channel c sits at byte address c*0x40 + 0x10. Bit n enables source n, and a read returns exactly the last value written.
- R3: Channel output c equals the OR over all sources of (source AND mask bit), registered once. It follows the inputs seen at the previous clock edge.
- R4: The vector of channel c sits at address c*0x40 + 0x04. For a selected source index i it reads (48 + i) * 4, so index = (vector >> 2) - 48.
- R5: When several enabled sources are active, the vector names the lowest-numbered one.
- R6: The vector reads 0 whenever no enabled source of that channel is active. Disabled active sources never appear in it.
- R7: Sources are not held. Once a source drops, the output falls at the next edge and a later vector read no longer reports it.
- R8: Writing 1 to bit 0 of the control word at c*0x40 + 0x00 clears channel c's mask and output at that edge. Other channels are untouched.
- R9: Bit 0 of the control word always reads 0. Bit 31 reports the channel's registered output.
- R10: The vector is read-only. A write to its address changes no mask and no output.
- R11: Read data appears one cycle after a read request. Offsets other than 0x00, 0x04 and 0x10, and addresses with any bit above the channel field set, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Level-sensitive interrupt source lines |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read |
| ch_irq_o | output | 8 | One interrupt output per channel |

## Verification
Two events can land in the same clock cycle: a source edge and a register access that depends on that source. One case is a vector read issued while the source is changing. The other is a channel reset written while that channel's enabled sources are high. The bench changes the sources on the falling edge just before a read or reset write, so both take effect at one rising edge. For reads it requires the vector and the outputs to reflect the new source levels. For resets it requires the output to be low right after the write and to stay low until the mask is rewritten, while neighbouring channels keep firing.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned VEC_BASE    = 48;
  localparam int unsigned VEC_SHIFT   = 2;
  localparam int unsigned CH_LSB      = 6;   // 0x40 stride between channels
  localparam logic [5:0]  OFS_CTRL    = 6'h00;
  localparam logic [5:0]  OFS_VEC     = 6'h04;
  localparam logic [5:0]  OFS_MASK    = 6'h10;
  localparam int unsigned CTRL_RST_B  = 0;
  localparam int unsigned CTRL_IRQ_B  = 31;

  // Vector word for a selected source; zero when nothing is selected.
  function automatic logic [DATA_W-1:0] vec_code(input logic found,
                                                 input int unsigned idx);
    if (!found) return '0;
    return DATA_W'((idx + VEC_BASE) << VEC_SHIFT);
  endfunction

  // Mask of all bit positions strictly below idx.
  function automatic logic [DATA_W-1:0] below_mask(input int unsigned idx);
    return (DATA_W'(1) << idx) - DATA_W'(1);
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 32,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // Scan downward so the lowest set bit is the one left standing.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        found_o = 1'b1;
        idx_o   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_chan.sv
module irq_chan
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_wdata,
  input  logic               chan_rst_req,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o,
  output logic [DATA_W-1:0]  vec_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic               irq_q;
  logic               rst_q;       // self-clearing reset marker
  logic [NUM_SRC-1:0] hits;
  logic               found;
  logic [IW-1:0]      sel_idx;
  logic [DATA_W-1:0]  lower_hits;

  assign hits = src_i & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mask_q <= '0;
    else if (chan_rst_req) mask_q <= '0;
    else if (mask_we)      mask_q <= mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            irq_q <= 1'b0;
    else if (chan_rst_req) irq_q <= 1'b0;
    else                   irq_q <= |hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= chan_rst_req;
  end

  irq_prio_enc #(.N(NUM_SRC)) u_enc (
    .req_i  (hits),
    .found_o(found),
    .idx_o  (sel_idx)
  );

  assign vec_o      = vec_code(found, int'(sel_idx));
  assign lower_hits = DATA_W'(hits) & below_mask(int'(sel_idx));
  assign mask_o     = mask_q;
  assign irq_o      = irq_q;

  assert_out_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(chan_rst_req)) |-> (irq_q == $past(found)));

  assert_rst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> (mask_q == '0 && !irq_q));

  assert_vec_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (vec_o == '0));

  assert_vec_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (vec_o[1:0] == 2'b00 && (vec_o >> VEC_SHIFT) >= VEC_BASE));

  assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (hits[sel_idx] && lower_hits == '0));
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 12,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned HI_W = ADDR_W - CH_LSB - CH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0]  mask_we,
  output logic [NUM_SRC-1:0] mask_wdata,
  output logic [NUM_CH-1:0]  chan_rst_req,
  input  logic [NUM_SRC-1:0] masks_i [NUM_CH],
  input  logic [NUM_CH-1:0]  irqs_i,
  input  logic [DATA_W-1:0]  vecs_i  [NUM_CH]
);
  logic [5:0]        ofs;
  logic [CH_W-1:0]   ch_sel;
  logic              in_range;
  logic              wr_hit;
  logic              rd_hit;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign ofs    = bus_addr[5:0];
  assign ch_sel = bus_addr[CH_LSB +: CH_W];

  generate
    if (HI_W > 0) begin : g_hi
      assign in_range = (bus_addr[ADDR_W-1 -: HI_W] == '0) &&
                        (int'(ch_sel) < NUM_CH);
    end else begin : g_nohi
      assign in_range = (int'(ch_sel) < NUM_CH);
    end
  endgenerate

  assign wr_hit     = bus_valid && bus_write && in_range;
  assign rd_hit     = bus_valid && !bus_write;
  assign mask_wdata = bus_wdata[NUM_SRC-1:0];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      assign mask_we[c]      = wr_hit && (int'(ch_sel) == c) && (ofs == OFS_MASK);
      assign chan_rst_req[c] = wr_hit && (int'(ch_sel) == c) && (ofs == OFS_CTRL)
                               && bus_wdata[CTRL_RST_B];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (in_range) begin
      unique case (ofs)
        OFS_CTRL: rd_mux[CTRL_IRQ_B] = irqs_i[ch_sel];
        OFS_VEC:  rd_mux = vecs_i[ch_sel];
        OFS_MASK: rd_mux = DATA_W'(masks_i[ch_sel]);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_hit) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  assert_one_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_we));

  assert_vec_write_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && ofs == OFS_VEC) |-> (mask_we == '0 && chan_rst_req == '0));

  assert_ctrl_rst_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && ofs == OFS_CTRL) |=> (bus_rdata[CTRL_RST_B] == 1'b0));

  assert_outside_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> (mask_we == '0 && chan_rst_req == '0));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CH-1:0]  ch_irq_o
);
  logic [NUM_CH-1:0]  mask_we;
  logic [NUM_SRC-1:0] mask_wdata;
  logic [NUM_CH-1:0]  chan_rst_req;
  logic [NUM_SRC-1:0] masks [NUM_CH];
  logic [DATA_W-1:0]  vecs  [NUM_CH];
  logic [NUM_CH-1:0]  irqs;

  irq_regif #(
    .NUM_CH (NUM_CH),
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W)
  ) u_regif (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .mask_we     (mask_we),
    .mask_wdata  (mask_wdata),
    .chan_rst_req(chan_rst_req),
    .masks_i     (masks),
    .irqs_i      (irqs),
    .vecs_i      (vecs)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      irq_chan #(.NUM_SRC(NUM_SRC)) u_chan (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .mask_we     (mask_we[c]),
        .mask_wdata  (mask_wdata),
        .chan_rst_req(chan_rst_req[c]),
        .mask_o      (masks[c]),
        .irq_o       (irqs[c]),
        .vec_o       (vecs[c])
      );
    end
  endgenerate

  assign ch_irq_o = irqs;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (ch_irq_o == '0));
endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  ch_irq_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;   // 50 MHz

  irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_irq_o(ch_irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [11:0] ra(input int ch, input int ofs);
    return 12'(ch * 64 + ofs);
  endfunction

  function automatic logic [31:0] pat(input int ch);
    return (32'h9e37_79b9 * (ch + 1)) ^ (32'h0000_0001 << (ch * 3));
  endfunction

  // Expected vector: scan upward, first hit wins, (idx + 48) * 4.
  function automatic logic [31:0] exp_vec(input logic [31:0] s, input logic [31:0] m);
    for (int i = 0; i < 32; i++)
      if (s[i] && m[i]) return 32'((i + 48) * 4);
    return 32'd0;
  endfunction

  function automatic logic [7:0] exp_irq(input logic [31:0] s, input logic [31:0] m [8]);
    logic [7:0] r;
    for (int c = 0; c < 8; c++) r[c] = (s & m[c]) != 0;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m [8];
    src_i = 32'hffff_ffff;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state with all sources high
    chk("R1 outputs", 32'(ch_irq_o), 32'd0);
    for (int c = 0; c < 8; c++) begin
      rd(ra(c, 'h10), d); chk("R1 mask", d, 32'd0);
      rd(ra(c, 'h04), d); chk("R1 vector", d, 32'd0);
    end
    chk("R1 outputs stay low", 32'(ch_irq_o), 32'd0);
    src_i = '0;

    // R2: masks read back exactly, per channel
    for (int c = 0; c < 8; c++) begin m[c] = pat(c); wr(ra(c, 'h10), m[c]); end
    for (int c = 0; c < 8; c++) begin rd(ra(c, 'h10), d); chk("R2 readback", d, m[c]); end

    // R3/R4/R6: single-source sweep over every channel and source
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 32; i++) begin
        src_i = 32'h1 << i;
        rd(ra(c, 'h04), d);
        chk("R4/R6 vector", d, exp_vec(src_i, m[c]));
        chk("R3 outputs", 32'(ch_irq_o), 32'(exp_irq(src_i, m)));
      end
    end

    // R5: several active sources, lowest enabled wins
    m[0] = 32'hffff_ffff; wr(ra(0, 'h10), m[0]);
    m[1] = 32'hffff_0ff0; wr(ra(1, 'h10), m[1]);
    for (int i = 0; i < 32; i++) begin
      src_i = (32'h1 << i) | (32'h1 << ((i * 7 + 3) % 32)) | 32'h8000_0000;
      rd(ra(0, 'h04), d); chk("R5 lowest ch0", d, exp_vec(src_i, m[0]));
      rd(ra(1, 'h04), d); chk("R5 lowest ch1", d, exp_vec(src_i, m[1]));
    end

    // R7: no latching, source pulse disappears
    src_i = 32'h0000_0010;
    @(negedge clk);
    chk("R7 rises", 32'(ch_irq_o[0]), 32'd1);
    src_i = '0;
    rd(ra(0, 'h04), d);
    chk("R7 vector gone", d, 32'd0);
    chk("R7 output fell", 32'(ch_irq_o[0]), 32'd0);

    // R8/R9: channel reset with sources active, same edge as the source rise
    for (int c = 0; c < 8; c++) begin m[c] = pat(c) | 32'h1; wr(ra(c, 'h10), m[c]); end
    src_i = 32'hffff_ffff;
    wr(ra(3, 'h00), 32'h1);
    chk("R8 output cleared", 32'(ch_irq_o[3]), 32'd0);
    m[3] = '0;
    rd(ra(3, 'h10), d); chk("R8 mask cleared", d, 32'd0);
    chk("R8 others alive", 32'(ch_irq_o), 32'(exp_irq(src_i, m)));
    rd(ra(2, 'h10), d); chk("R8 neighbour mask", d, m[2]);
    rd(ra(3, 'h00), d); chk("R9 ctrl ch3", d, 32'd0);
    rd(ra(2, 'h00), d); chk("R9 ctrl ch2 status", d, 32'h8000_0000);
    rd(ra(3, 'h04), d); chk("R8 vector after reset", d, 32'd0);

    // R10: vector is read-only
    wr(ra(1, 'h04), 32'hffff_ffff);
    rd(ra(1, 'h10), d); chk("R10 mask untouched", d, m[1]);
    rd(ra(1, 'h04), d); chk("R10 vector", d, exp_vec(src_i, m[1]));
    chk("R10 outputs", 32'(ch_irq_o), 32'(exp_irq(src_i, m)));

    // R11: unmapped offsets and out-of-range addresses
    rd(ra(0, 'h08), d); chk("R11 hole read", d, 32'd0);
    rd(12'h810, d); chk("R11 high addr read", d, 32'd0);
    wr(12'h810, 32'h0);
    wr(12'h800, 32'h1);
    rd(ra(0, 'h10), d); chk("R11 high write ignored", d, m[0]);
    wr(ra(0, 'h20), 32'h0);
    rd(ra(0, 'h10), d); chk("R11 hole write ignored", d, m[0]);
    chk("R11 outputs", 32'(ch_irq_o), 32'(exp_irq(src_i, m)));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule